// File: doc/BRIEF.md
# Dual-Lane Bidirectional Serial-to-Parallel Channel Driver

This block turns two serial bit streams into 64 parallel channel-enable signals for a display panel driver. Two 32-stage shift lanes advance together on every rising clock edge. Lane 1 feeds channels 1 to 32 and lane 2 feeds channels 33 to 64. A direction input decides which way the lanes shift. It also decides which of each lane's two bidirectional pins (side A and side B) takes serial data in, and which one passes the lane's last stage on to the next device in a chain. Each pin is split into an input, an output and an output-enable, so the tri-state pads can stay outside the block.

A 64-bit latch bank sits between the lanes and the channel outputs. While the latch enable is high, the latches pass the shift contents straight through. While it is low, they keep what they last captured, and the lanes go on shifting behind them. An active-low blank input forces every channel on. When the blank input is high, a channel is on exactly when its latched bit is 0.

Top module: `dual_lane_sipo_driver`

## Requirements
- R1: With `shift_fwd` = 1, each rising edge moves every lane stage i to stage i+1 and loads stage 0 of lane k from `pa_in[k]`.
- R2: With `shift_fwd` = 0, each rising edge moves every lane stage i to stage i-1 and loads stage 31 of lane k from `pb_in[k]`.
- R3: `pa_out[k]` always shows stage 0 of lane k and `pb_out[k]` always shows stage 31. `pb_oe` equals `shift_fwd` and `pa_oe` equals its inverse, so the cascade pin is the one that drives.
- R4: The two lanes shift independently of each other. Channel index is lane×32 + stage, and `chan_on` bit 0 is channel 1.
- R5: While `latch_en` is high, the latches follow the lanes, so the value shifted in on an edge appears on `chan_on` in that same cycle.
- R6: While `latch_en` is low, the latched values, and with `blank_n` high also `chan_on`, stay unchanged even though the lanes keep shifting.
- R7: With `blank_n` = 0, all 64 bits of `chan_on` are 1, whatever the latch contents.
- R8: With `blank_n` = 1, each `chan_on` bit is the inverse of its latched bit (latched 0 means on).
- R9: A synchronous active-high `rst` clears both lanes and all latches. After reset with `blank_n` = 1, every `chan_on` bit is 1 and all cascade outputs are 0.
- R10: A change of `shift_fwd` between edges takes effect at the next rising edge. Each edge shifts in the direction sampled at that edge.
- R11: Shifting and the cascade outputs do not depend on `latch_en` or `blank_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared shift clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_fwd | input | 1 | 1 = forward shift (channel 1 toward 64), 0 = reverse |
| latch_en | input | 1 | 1 = latches transparent, 0 = hold |
| blank_n | input | 1 | 0 = force all channels on |
| pa_in | input | 2 | Side-A pin input per lane (serial in when forward) |
| pb_in | input | 2 | Side-B pin input per lane (serial in when reverse) |
| pa_out | output | 2 | Side-A pin output per lane (stage 0) |
| pb_out | output | 2 | Side-B pin output per lane (stage 31) |
| pa_oe | output | 2 | Side-A pin output-enable per lane |
| pb_oe | output | 2 | Side-B pin output-enable per lane |
| chan_on | output | 64 | Channel-on vector, bit 0 = channel 1 |

## Verification
The checks assume that `latch_en`, `blank_n`, `shift_fwd` and the serial pins change only between clock edges and are steady across each rising edge. In particular, the latch enable never pulses high and low again between two edges, because the latches capture on the edge. The bench drives all inputs a few nanoseconds after each rising edge and samples the outputs before it changes anything. The hold and blanking checks then compare `chan_on` over whole cycles in which the control level did not move.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;

  typedef enum logic {
    SHIFT_REV = 1'b0,
    SHIFT_FWD = 1'b1
  } shift_dir_e;

  // Flat channel index of a stage inside a lane.
  function automatic int chan_index(input int lane, input int stage, input int lane_w);
    return lane * lane_w + stage;
  endfunction

endpackage

// File: rtl/sipo_lane.sv
module sipo_lane
  import sipo_drv_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  shift_dir_e        dir,
  input  logic              side_a_in,
  input  logic              side_b_in,
  output logic [LANE_W-1:0] stage_q,
  output logic [LANE_W-1:0] stage_d,
  output logic              side_a_out,
  output logic              side_b_out,
  output logic              side_a_oe,
  output logic              side_b_oe
);

  localparam int LAST = LANE_W - 1;

  // Next lane content for one edge in the chosen direction.
  function automatic logic [LANE_W-1:0] advance(
    input logic [LANE_W-1:0] cur,
    input shift_dir_e        d,
    input logic              a_bit,
    input logic              b_bit
  );
    logic [LANE_W-1:0] nxt;
    if (d == SHIFT_FWD) begin
      nxt = {cur[LAST-1:0], a_bit};
    end else begin
      nxt = {b_bit, cur[LAST:1]};
    end
    return nxt;
  endfunction

  assign stage_d = advance(stage_q, dir, side_a_in, side_b_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  // Both ends are always visible; the enables pick the driving pin.
  assign side_a_out = stage_q[0];
  assign side_b_out = stage_q[LAST];
  assign side_b_oe  = (dir == SHIFT_FWD);
  assign side_a_oe  = (dir == SHIFT_REV);

endmodule

// File: rtl/sipo_latch_bank.sv
module sipo_latch_bank #(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           open_en,
  input  logic [NCH-1:0] shift_q,
  input  logic [NCH-1:0] shift_d,
  output logic [NCH-1:0] latched
);

  logic [NCH-1:0] held_q;

  // Capture what the lanes load on an edge while open, so the held value
  // equals the lane content seen just before the enable drops.
  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (open_en) begin
      held_q <= shift_d;
    end
  end

  assign latched = open_en ? shift_q : held_q;

endmodule

// File: rtl/sipo_blank_stage.sv
module sipo_blank_stage #(
  parameter int NCH = 64
) (
  input  logic           blank_n,
  input  logic [NCH-1:0] latched,
  output logic [NCH-1:0] chan_on
);

  function automatic logic [NCH-1:0] on_map(input logic bl_n, input logic [NCH-1:0] bits);
    return bl_n ? ~bits : {NCH{1'b1}};
  endfunction

  assign chan_on = on_map(blank_n, latched);

endmodule

// File: rtl/dual_lane_sipo_driver.sv
module dual_lane_sipo_driver
  import sipo_drv_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int NLANE  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      shift_fwd,
  input  logic                      latch_en,
  input  logic                      blank_n,
  input  logic [NLANE-1:0]          pa_in,
  input  logic [NLANE-1:0]          pb_in,
  output logic [NLANE-1:0]          pa_out,
  output logic [NLANE-1:0]          pb_out,
  output logic [NLANE-1:0]          pa_oe,
  output logic [NLANE-1:0]          pb_oe,
  output logic [NLANE*LANE_W-1:0]   chan_on
);

  localparam int NCH = NLANE * LANE_W;

  shift_dir_e     dir_sel;
  logic [NCH-1:0] sr_bits;
  logic [NCH-1:0] sr_next;
  logic [NCH-1:0] latch_bits;

  assign dir_sel = shift_fwd ? SHIFT_FWD : SHIFT_REV;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int BASE = chan_index(g, 0, LANE_W);
    sipo_lane #(.LANE_W(LANE_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .dir        (dir_sel),
      .side_a_in  (pa_in[g]),
      .side_b_in  (pb_in[g]),
      .stage_q    (sr_bits[BASE +: LANE_W]),
      .stage_d    (sr_next[BASE +: LANE_W]),
      .side_a_out (pa_out[g]),
      .side_b_out (pb_out[g]),
      .side_a_oe  (pa_oe[g]),
      .side_b_oe  (pb_oe[g])
    );
  end

  sipo_latch_bank #(.NCH(NCH)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .open_en (latch_en),
    .shift_q (sr_bits),
    .shift_d (sr_next),
    .latched (latch_bits)
  );

  sipo_blank_stage #(.NCH(NCH)) u_blank (
    .blank_n (blank_n),
    .latched (latch_bits),
    .chan_on (chan_on)
  );

endmodule

// File: rtl/dual_lane_sipo_driver_chk.sv
module dual_lane_sipo_driver_chk #(
  parameter int LANE_W = 32,
  parameter int NLANE  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    shift_fwd,
  input logic                    latch_en,
  input logic                    blank_n,
  input logic [NLANE-1:0]        pa_in,
  input logic [NLANE-1:0]        pb_in,
  input logic [NLANE-1:0]        pa_out,
  input logic [NLANE-1:0]        pb_out,
  input logic [NLANE-1:0]        pa_oe,
  input logic [NLANE-1:0]        pb_oe,
  input logic [NLANE*LANE_W-1:0] chan_on,
  input logic [NLANE*LANE_W-1:0] sr_bits
);

  // R1
  fwd_load_chk: assert property (@(posedge clk) disable iff (rst)
    shift_fwd |=> (pa_out == $past(pa_in)));

  // R2
  rev_load_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_fwd |=> (pb_out == $past(pb_in)));

  // R3
  pin_role_chk: assert property (@(posedge clk) disable iff (rst)
    (pb_oe == {NLANE{shift_fwd}}) && (pa_oe == {NLANE{!shift_fwd}}));

  // R5
  transparent_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_en && blank_n) |-> (chan_on == ~sr_bits));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch_en && $past(!latch_en) && blank_n && $past(blank_n) && !$past(rst))
      |-> $stable(chan_on));

  // R7
  blank_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_n |-> (&chan_on));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && blank_n) |-> ((&chan_on) && (pa_out == '0) && (pb_out == '0)));

endmodule

bind dual_lane_sipo_driver dual_lane_sipo_driver_chk #(
  .LANE_W(LANE_W),
  .NLANE (NLANE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_fwd (shift_fwd),
  .latch_en  (latch_en),
  .blank_n   (blank_n),
  .pa_in     (pa_in),
  .pb_in     (pb_in),
  .pa_out    (pa_out),
  .pb_out    (pb_out),
  .pa_oe     (pa_oe),
  .pb_oe     (pb_oe),
  .chan_on   (chan_on),
  .sr_bits   (sr_bits)
);

// File: tb/tb_dual_lane_sipo_driver.sv
`timescale 1ns/1ps
module tb_dual_lane_sipo_driver;

  localparam int LW  = 32;
  localparam int NL  = 2;
  localparam int NCH = LW * NL;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           shift_fwd = 1'b1;
  logic           latch_en = 1'b1;
  logic           blank_n = 1'b1;
  logic [NL-1:0]  pa_in = '0;
  logic [NL-1:0]  pb_in = '0;
  logic [NL-1:0]  pa_out, pb_out, pa_oe, pb_oe;
  logic [NCH-1:0] chan_on;

  logic [NCH-1:0] m_sr = '0;
  logic [NCH-1:0] m_held = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dual_lane_sipo_driver #(.LANE_W(LW), .NLANE(NL)) dut (
    .clk(clk), .rst(rst), .shift_fwd(shift_fwd), .latch_en(latch_en),
    .blank_n(blank_n), .pa_in(pa_in), .pb_in(pb_in), .pa_out(pa_out),
    .pb_out(pb_out), .pa_oe(pa_oe), .pb_oe(pb_oe), .chan_on(chan_on)
  );

  // Reference model built from the requirements: one call per rising edge.
  task automatic step();
    logic [NCH-1:0] nxt;
    nxt = m_sr;
    for (int k = 0; k < NL; k++) begin
      for (int i = 0; i < LW; i++) begin
        if (shift_fwd) nxt[k*LW+i] = (i == 0) ? pa_in[k] : m_sr[k*LW+i-1];
        else           nxt[k*LW+i] = (i == LW-1) ? pb_in[k] : m_sr[k*LW+i+1];
      end
    end
    @(posedge clk);
    if (rst) begin
      m_sr = '0;
      m_held = '0;
    end else begin
      m_sr = nxt;
      if (latch_en) m_held = nxt;
    end
    #2;
  endtask

  function automatic logic [NCH-1:0] exp_chan();
    logic [NCH-1:0] lat;
    lat = latch_en ? m_sr : m_held;
    return blank_n ? ~lat : {NCH{1'b1}};
  endfunction

  task automatic cmp_vec(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmp_bit(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [NL-1:0] ea, eb;
    for (int k = 0; k < NL; k++) begin
      ea[k] = m_sr[k*LW];
      eb[k] = m_sr[k*LW+LW-1];
    end
    cmp_vec({tag, " chan_on"}, chan_on, exp_chan());
    cmp_bit({tag, " R3 pa_out"}, pa_out, ea);
    cmp_bit({tag, " R3 pb_out"}, pb_out, eb);
    cmp_bit({tag, " R3 pa_oe"}, pa_oe, {NL{!shift_fwd}});
    cmp_bit({tag, " R3 pb_oe"}, pb_oe, {NL{shift_fwd}});
  endtask

  task automatic t_reset();
    rst = 1'b1; blank_n = 1'b1; latch_en = 1'b1; pa_in = '1; pb_in = '1;
    step(); step();
    rst = 1'b0;
    #1;
    cmp_vec("R9 all on after reset", chan_on, {NCH{1'b1}});
    cmp_bit("R9 pa_out cleared", pa_out, '0);
    cmp_bit("R9 pb_out cleared", pb_out, '0);
  endtask

  task automatic t_forward();
    shift_fwd = 1'b1; latch_en = 1'b1; blank_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      pa_in = {logic'(i[0] ^ i[2]), logic'((i % 3) == 0)};
      pb_in = 2'b11;
      step();
      check_all("R1 R5 R8 forward");
    end
  endtask

  task automatic t_reverse();
    shift_fwd = 1'b0; latch_en = 1'b1; blank_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      pb_in = {logic'((i % 5) < 2), logic'(i[1])};
      pa_in = 2'b00;
      step();
      check_all("R2 R5 reverse");
    end
  endtask

  task automatic t_hold();
    logic [NCH-1:0] snap;
    shift_fwd = 1'b1; latch_en = 1'b1; blank_n = 1'b1; pa_in = 2'b10;
    step();
    snap = chan_on;
    latch_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      pa_in = {logic'(i[0]), logic'(!i[1])};
      step();
      cmp_vec("R6 held output", chan_on, snap);
      check_all("R11 shift under hold");
    end
    latch_en = 1'b1;
    #1;
    check_all("R5 reopen");
  endtask

  task automatic t_blank();
    shift_fwd = 1'b0; latch_en = 1'b1; blank_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      pb_in = {logic'(i[0]), logic'(i[1])};
      step();
      cmp_vec("R7 blank all on", chan_on, {NCH{1'b1}});
      check_all("R11 shift under blank");
    end
    blank_n = 1'b1;
    #1;
    cmp_vec("R8 unblank inverse", chan_on, ~m_sr);
  endtask

  task automatic t_dir_switch();
    latch_en = 1'b1; blank_n = 1'b1; pa_in = 2'b01; pb_in = 2'b10;
    for (int i = 0; i < 12; i++) begin
      shift_fwd = i[0];
      #1;
      check_all("R10 before edge");
      step();
      check_all("R10 after edge");
    end
  endtask

  task automatic t_lanes();
    shift_fwd = 1'b1; latch_en = 1'b1; blank_n = 1'b1;
    pa_in = 2'b01;
    for (int i = 0; i < LW; i++) step();
    cmp_vec("R4 lane1 all off", {32'd0, chan_on[LW-1:0]}, 64'd0);
    cmp_vec("R4 lane2 all on", {32'd0, chan_on[NCH-1:LW]}, {32'd0, 32'hFFFF_FFFF});
    check_all("R4 lanes");
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_forward();
    t_reverse();
    t_hold();
    t_blank();
    t_dir_switch();
    t_lanes();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule